// File: doc/BRIEF.md
# Presettable Up/Down Counter with Terminal Flags

This block is a synchronous counter whose direction is chosen on every clock by one select input. A parameter builds it in one of two variants. The binary variant counts through every value of its width and wraps at both ends. The decade variant counts 0 to 9 and wraps from 9 to 0 going up, or from 0 to 9 going down.

An active-low load control presets the count from a data input. The preset value shows on the count output at once, without waiting for a clock edge, and the preset takes priority over counting. A limit flag reports that the count is at the end of its range in the selected direction. An active-low ripple output pulses during the low half of the clock while that is true and counting is enabled. Several stages can be chained by feeding one stage's ripple output into the enable of the next.

Top module: `updn_ctr`

## Requirements
- R1: While `rst_n` is low, the stored count is 0. The reset acts without a clock edge, and the count output reads 0 unless a load is active.
- R2: In binary mode with `dn_up` = 0 (up), each rising clock edge with `cnt_en_n` low adds 1 to the count. The count wraps from 15 to 0.
- R3: In binary mode with `dn_up` = 1 (down), each enabled rising edge subtracts 1 from the count. The count wraps from 0 to 15.
- R4: In decade mode counting up, the count steps through 0 to 9, and the step after 9 returns to 0.
- R5: In decade mode counting down, the count steps down by 1, and the step after 0 goes to 9.
- R6: In decade mode, a loaded value from 10 to 15 is back in range after one enabled clock edge. That edge gives 0 when counting up and 9 when counting down.
- R7: While `cnt_en_n` is high and no load is active, clock edges leave the count unchanged.
- R8: While `load_n` is low, the count output equals `load_val` immediately, and clock edges do not count. After `load_n` returns high, the loaded value is kept until the next enabled edge.
- R9: `at_limit` is high exactly when counting up with the count at 15 (binary) or 9 (decade), or counting down with the count at 0. It follows the shown count and the direction, whether or not counting is enabled.
- R10: `ripple_n` is low only while `clk` is low, `cnt_en_n` is low and `at_limit` is high. At all other times it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; count changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the stored count |
| cnt_en_n | input | 1 | Active-low count enable |
| load_n | input | 1 | Active-low preset; passes `load_val` straight to the output |
| load_val | input | WIDTH | Preset data |
| dn_up | input | 1 | Direction: 0 counts up, 1 counts down |
| count | output | WIDTH | Current count |
| at_limit | output | 1 | High at the end of the range in the selected direction |
| ripple_n | output | 1 | Active-low cascade pulse during the low clock phase |

## Verification
The assertions check on every cycle that each enabled edge gives the correct step in both directions, including both wraps and the return from out-of-range decade values. They also check that a disabled counter holds, that the preset reaches the output and is kept, that the limit flag points to the correct end of the range, and that the ripple output stays high whenever counting is off. Only the bench scenarios show the timing of the ripple output inside a clock period, high in the high phase and low in the low phase. The same holds for the output changing in the middle of a cycle as soon as a load is applied, and for the two variants running side by side from the same stimulus.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   typedef enum logic {
      MODE_BIN = 1'b0,
      MODE_DEC = 1'b1
   } ctr_mode_e;

   // Highest legal count for a variant of a given width.
   function automatic int unsigned ctr_limit(ctr_mode_e mode, int unsigned width);
      if (mode == MODE_DEC)
         return 9;
      return (1 << width) - 1;
   endfunction

endpackage

// File: rtl/ctr_step.sv
module ctr_step
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter ctr_mode_e   MODE  = MODE_BIN
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             down,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] LIMIT = WIDTH'(ctr_limit(MODE, WIDTH));
   localparam logic [WIDTH-1:0] ONE   = WIDTH'(1);
   localparam logic [WIDTH-1:0] ZERO  = '0;

   generate
      if (MODE == MODE_BIN) begin : g_bin
         // Full-range binary: natural wrap at both ends.
         always_comb begin
            if (down) nxt = cur - ONE;
            else      nxt = cur + ONE;
         end
      end else begin : g_dec
         // Decade: wrap at 9, and pull any out-of-range value back in one step.
         always_comb begin
            if (down) begin
               if (cur == ZERO || cur > LIMIT) nxt = LIMIT;
               else                            nxt = cur - ONE;
            end else begin
               if (cur >= LIMIT) nxt = ZERO;
               else              nxt = cur + ONE;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ctr_term.sv
module ctr_term
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter ctr_mode_e   MODE  = MODE_BIN
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] cur,
   input  logic             down,
   input  logic             en_n,
   output logic             at_limit,
   output logic             ripple_n
);

   localparam logic [WIDTH-1:0] LIMIT = WIDTH'(ctr_limit(MODE, WIDTH));

   logic top_hit;
   logic bot_hit;

   assign top_hit  = (cur == LIMIT);
   assign bot_hit  = (cur == '0);
   assign at_limit = down ? bot_hit : top_hit;

   // Pulse only in the low clock phase so a chained stage sees a clean edge.
   assign ripple_n = ~(at_limit & ~en_n & ~clk);

endmodule

// File: rtl/updn_ctr.sv
module updn_ctr
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter ctr_mode_e   MODE  = MODE_BIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en_n,
   input  logic             load_n,
   input  logic [WIDTH-1:0] load_val,
   input  logic             dn_up,
   output logic [WIDTH-1:0] count,
   output logic             at_limit,
   output logic             ripple_n
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("updn_ctr: WIDTH must be at least 1");
      end
      if (MODE == MODE_DEC && WIDTH != 4) begin : g_bad_dec
         $error("updn_ctr: decade variant needs WIDTH of 4");
      end
   endgenerate

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] step_nxt;
   logic [WIDTH-1:0] shown;

   // The preset bypasses the register so it shows without a clock edge.
   assign shown = load_n ? cnt_q : load_val;
   assign count = shown;

   ctr_step #(
      .WIDTH (WIDTH),
      .MODE  (MODE)
   ) u_step (
      .cur  (cnt_q),
      .down (dn_up),
      .nxt  (step_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!load_n)  cnt_q <= load_val;
      else if (!cnt_en_n) cnt_q <= step_nxt;
   end

   ctr_term #(
      .WIDTH (WIDTH),
      .MODE  (MODE)
   ) u_term (
      .clk      (clk),
      .cur      (shown),
      .down     (dn_up),
      .en_n     (cnt_en_n),
      .at_limit (at_limit),
      .ripple_n (ripple_n)
   );

endmodule

// File: rtl/updn_ctr_chk.sv
module updn_ctr_chk
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter ctr_mode_e   MODE  = MODE_BIN
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en_n,
   input logic             load_n,
   input logic [WIDTH-1:0] load_val,
   input logic             dn_up,
   input logic [WIDTH-1:0] count,
   input logic             at_limit,
   input logic             ripple_n
);

   localparam logic [WIDTH-1:0] LIMIT = WIDTH'(ctr_limit(MODE, WIDTH));
   localparam logic [WIDTH-1:0] ONE   = WIDTH'(1);

   // R2 / R4: enabled up step below the limit adds one
   a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !cnt_en_n && !dn_up && count < LIMIT)
      |=> (!load_n || count == $past(count) + ONE));

   // R4: up wrap at the limit
   a_r4_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !cnt_en_n && !dn_up && count == LIMIT)
      |=> (!load_n || count == '0));

   // R3 / R5: enabled down step within range subtracts one
   a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !cnt_en_n && dn_up && count != '0 && count <= LIMIT)
      |=> (!load_n || count == $past(count) - ONE));

   // R5: down wrap from zero
   a_r5_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !cnt_en_n && dn_up && count == '0)
      |=> (!load_n || count == LIMIT));

   // R6: any enabled edge leaves the count in range
   a_r6_recover: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !cnt_en_n)
      |=> (!load_n || count <= LIMIT));

   // R7: disabled counter holds
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && cnt_en_n)
      |=> (!load_n || count == $past(count)));

   // R8: preset shows on the output and is kept after release
   a_r8_load_shows: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |-> count == load_val);
   a_r8_load_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> (!load_n || count == $past(load_val)));

   // R9: flag points at the end of range for the direction
   a_r9_flag_end: assert property (@(posedge clk) disable iff (!rst_n)
      at_limit |-> (dn_up ? (count == '0) : (count == LIMIT)));

   // R10: no ripple pulse unless enabled and at the limit
   a_r10_ripple_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ripple_n |-> (!cnt_en_n && at_limit));

endmodule

bind updn_ctr updn_ctr_chk #(.WIDTH(WIDTH), .MODE(MODE)) u_chk (.*);

// File: tb/updn_ctr_bench.sv
module updn_ctr_bench;
   import ctr_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_en_n = 1'b1;
   logic       load_n = 1'b1;
   logic [3:0] load_val = 4'd0;
   logic       dn_up = 1'b0;

   logic [3:0] b_count;
   logic       b_lim;
   logic       b_rip;
   logic [3:0] d_count;
   logic       d_lim;
   logic       d_rip;

   int total = 0;
   int bad   = 0;
   int mb = 0;   // binary reference state
   int md = 0;   // decade reference state
   string tag = "R1";

   always #4 clk = ~clk;

   updn_ctr #(.WIDTH(4), .MODE(MODE_BIN)) u_updn_ctr_bin (
      .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .load_n(load_n),
      .load_val(load_val), .dn_up(dn_up),
      .count(b_count), .at_limit(b_lim), .ripple_n(b_rip));

   updn_ctr #(.WIDTH(4), .MODE(MODE_DEC)) u_updn_ctr (
      .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .load_n(load_n),
      .load_val(load_val), .dn_up(dn_up),
      .count(d_count), .at_limit(d_lim), .ripple_n(d_rip));

   function automatic int ref_next(int m, bit dn, bit dec);
      if (!dec) return dn ? (m + 15) % 16 : (m + 1) % 16;
      if (dn)   return (m == 0 || m > 9) ? 9 : m - 1;
      return (m >= 9) ? 0 : m + 1;
   endfunction

   // Reference model, updated on each rising edge from the held inputs.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mb <= 0; md <= 0;
      end else if (!load_n) begin
         mb <= int'(load_val); md <= int'(load_val);
      end else if (!cnt_en_n) begin
         mb <= ref_next(mb, dn_up, 1'b0);
         md <= ref_next(md, dn_up, 1'b1);
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Compare both instances against the model in the low clock phase.
   task automatic compare();
      int vb, vd, lb, ld, lim;
      vb = load_n ? mb : int'(load_val);
      vd = load_n ? md : int'(load_val);
      lb = dn_up ? int'(vb == 0) : int'(vb == 15);
      ld = dn_up ? int'(vd == 0) : int'(vd == 9);
      chk(int'(b_count) == vb, tag, "binary count", int'(b_count), vb);
      chk(int'(d_count) == vd, tag, "decade count", int'(d_count), vd);
      chk(int'(b_lim) == lb, "R9", "binary at_limit", int'(b_lim), lb);
      chk(int'(d_lim) == ld, "R9", "decade at_limit", int'(d_lim), ld);
      lim = (!cnt_en_n && lb == 1) ? 0 : 1;
      chk(int'(b_rip) == lim, "R10", "binary ripple_n low phase", int'(b_rip), lim);
      lim = (!cnt_en_n && ld == 1) ? 0 : 1;
      chk(int'(d_rip) == lim, "R10", "decade ripple_n low phase", int'(d_rip), lim);
   endtask

   // One clock: check the high phase, apply inputs, check the low phase.
   task automatic cyc(bit en, bit ld, bit dn, int val, string req);
      @(posedge clk);
      #1;
      chk(b_rip == 1'b1, "R10", "binary ripple_n high phase", int'(b_rip), 1);
      chk(d_rip == 1'b1, "R10", "decade ripple_n high phase", int'(d_rip), 1);
      #1;
      tag = req;
      cnt_en_n = !en;
      load_n   = !ld;
      dn_up    = dn;
      load_val = 4'(val);
      if (ld) begin
         #1;
         chk(int'(b_count) == val, "R8", "binary load bypass", int'(b_count), val);
         chk(int'(d_count) == val, "R8", "decade load bypass", int'(d_count), val);
      end
      @(negedge clk);
      #1;
      compare();
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (2) @(posedge clk);
      #1;
      chk(b_count == 4'd0, "R1", "binary reset", int'(b_count), 0);
      chk(d_count == 4'd0, "R1", "decade reset", int'(d_count), 0);
      #1 rst_n = 1'b1;

      // R2 / R4: count up across both wraps
      for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b0, 0, "R2_R4_up");
      // R3 / R5: count down across both wraps
      for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b1, 0, "R3_R5_down");
      // R7: hold while disabled, both directions
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, i[0], 0, "R7");
      // R8: load wins over counting, then is kept while disabled
      cyc(1'b1, 1'b1, 1'b0, 7, "R8");
      cyc(1'b0, 1'b0, 1'b0, 0, "R8");
      cyc(1'b0, 1'b0, 1'b0, 0, "R8");
      // R6: out-of-range decade loads, up and down
      cyc(1'b0, 1'b1, 1'b0, 12, "R6");
      cyc(1'b1, 1'b0, 1'b0, 0, "R6");
      cyc(1'b1, 1'b0, 1'b0, 0, "R6");
      cyc(1'b0, 1'b1, 1'b1, 15, "R6");
      cyc(1'b1, 1'b0, 1'b1, 0, "R6");
      cyc(1'b1, 1'b0, 1'b1, 0, "R6");
      cyc(1'b0, 1'b1, 1'b0, 10, "R6");
      cyc(1'b1, 1'b0, 1'b0, 0, "R6");
      // R9 / R10: flag and ripple at limits with enable on and off
      cyc(1'b0, 1'b1, 1'b0, 9, "R9");
      cyc(1'b1, 1'b0, 1'b0, 0, "R10");
      cyc(1'b0, 1'b1, 1'b1, 0, "R9");
      cyc(1'b1, 1'b0, 1'b1, 0, "R10");
      cyc(1'b0, 1'b1, 1'b0, 15, "R9");
      cyc(1'b1, 1'b0, 1'b0, 0, "R10");
      // R1: asynchronous clear in mid-cycle
      cyc(1'b1, 1'b1, 1'b0, 5, "R8");
      cyc(1'b0, 1'b0, 1'b0, 0, "R8");
      #2 rst_n = 1'b0;
      #1;
      chk(b_count == 4'd0, "R1", "binary async clear", int'(b_count), 0);
      chk(d_count == 4'd0, "R1", "decade async clear", int'(d_count), 0);
      @(posedge clk);
      #2 rst_n = 1'b1;
      for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 1'b0, 0, "R2_R4_up");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule